// File: doc/BRIEF.md
# Clock Control and Gating Unit

This block decides, cycle by cycle, which clock domains of a small microcontroller may run. It drives enables for the CPU, flash, I/O and ADC domains. It also drives power enables for the internal RC oscillator and the PLL, and it produces a 1 MHz reference tick divided from the RC oscillator. A lock flag qualifies the fast peripheral clock, which runs at 64 times the reference. One timer may take that fast clock as its source, but only once the lock flag is set. The analog oscillator, the PLL itself and the reset logic sit outside the block. Lock is modelled as a count of reference ticks.

A sleep state machine owns the gating. It has six states: RUN, IDLE, ADCNR, PDOWN, STBY and WOKEN.
- RUN moves to IDLE, ADCNR, PDOWN or STBY when the sleep request is high, the target chosen by the 2-bit mode code.
- Any sleep state moves to WOKEN when an asynchronous wake pulse has been captured. Wake takes priority.
- Otherwise, a sleep state moves back to RUN when the sleep request drops.
- WOKEN returns to RUN only once the sleep request drops.

The lock state machine has three states: OFF, SETTLE and LOCKED.
- OFF moves to SETTLE when the PLL is powered.
- SETTLE moves to LOCKED after 64 reference ticks.
- Either SETTLE or LOCKED falls back to OFF as soon as the PLL power is removed.

All enables are registered on the falling edge of the source clock, so the gated clocks cannot glitch.

Top module: `clkctl_top`

## Requirements
- R1: While reset is high, every domain enable and the RC enable read 1, the lock flag reads 0, and the PLL enable reads 1 exactly when the fuse input is 0.
- R2: The flash enable always equals the CPU enable. In RUN, all four domain enables read 1.
- R3: With sleep requested and mode code 00 (idle), the CPU and flash enables read 0, and the I/O and ADC enables read 1.
- R4: With sleep requested and mode code 01 (ADC noise reduction), the CPU, flash and I/O enables read 0, and the ADC enable reads 1.
- R5: With sleep requested and mode code 10 (power-down) or 11 (standby), all domain enables, the RC enable and the PLL enable read 0 whatever the register bit and fuse say. No reference ticks appear in these modes.
- R6: Outside those two deep modes, the PLL enable equals the register bit ORed with the inverted fuse input.
- R7: The reference tick pulses once every 2^S source cycles, where S is the RC frequency code: 0, 1, 2, 3 stand for 1, 2, 4, 8 MHz.
- R8: The lock flag rises only after 64 reference ticks with the PLL enabled. It clears on the cycle after the PLL enable goes low.
- R9: A wake pulse during any sleep state turns all domain enables back on. They stay on while the sleep request remains high.
- R10: Dropping the sleep request returns the block to RUN with all domain enables on.
- R11: The timer fast-source grant reads 1 only when it is requested and the lock flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Sleep request level |
| sleep_mode | input | 2 | Sleep mode code |
| wake_irq | input | 1 | Asynchronous wake pulse |
| pll_en_bit | input | 1 | PLL enable register bit |
| pll_fuse_n | input | 1 | PLL fuse, 0 = programmed |
| rc_freq_sel | input | 2 | RC oscillator frequency code |
| tmr_fast_sel | input | 1 | Timer requests the fast clock |
| cpu_clk_en | output | 1 | CPU domain enable |
| flash_clk_en | output | 1 | Flash domain enable |
| io_clk_en | output | 1 | I/O domain enable |
| adc_clk_en | output | 1 | ADC domain enable |
| rc_osc_en | output | 1 | RC oscillator power enable |
| pll_en | output | 1 | PLL power enable |
| ref_tick | output | 1 | 1 MHz reference tick |
| pll_lock | output | 1 | PLL lock flag |
| pck_timer_sel | output | 1 | Timer fast-clock grant |

## Verification
On every cycle, the assertions check the following relations:
- the ordering of the domain enables, in which a running CPU implies running flash, I/O and ADC;
- a powered PLL implies a running RC oscillator;
- the lock flag drops the cycle after the PLL loses power;
- the timer grant never appears without lock;
- a sleep request held low keeps the CPU running.

Only the bench scenarios can show the following:
- the exact enable pattern of each mode code;
- the wake behaviour while the request stays high;
- the tick rate for each RC code;
- the earliest and latest cycle at which lock appears.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_ADCNR = 2'b01,
        MODE_PDOWN = 2'b10,
        MODE_STBY  = 2'b11
    } slp_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_ADCNR,
        ST_PDOWN,
        ST_STBY,
        ST_WOKEN
    } gate_st_e;

    typedef enum logic [1:0] {
        LK_OFF,
        LK_SETTLE,
        LK_LOCKED
    } lock_st_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic rc;
    } dom_en_t;

endpackage

// File: rtl/clkctl_sleep_fsm.sv
module clkctl_sleep_fsm
    import clkctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic [1:0] mode,
    input  logic       wake_irq,
    output dom_en_t    dom_en
);

    gate_st_e state, state_d;
    logic     wake_seen;

    // Asynchronous capture of the wake pulse; the clock edge clears it
    always_ff @(posedge clk or posedge wake_irq) begin
        if (wake_irq) wake_seen <= 1'b1;
        else          wake_seen <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN: begin
                if (sleep_req) begin
                    unique case (slp_mode_e'(mode))
                        MODE_IDLE:  state_d = ST_IDLE;
                        MODE_ADCNR: state_d = ST_ADCNR;
                        MODE_PDOWN: state_d = ST_PDOWN;
                        MODE_STBY:  state_d = ST_STBY;
                    endcase
                end
            end
            ST_IDLE, ST_ADCNR, ST_PDOWN, ST_STBY: begin
                if (wake_seen)       state_d = ST_WOKEN;
                else if (!sleep_req) state_d = ST_RUN;
            end
            ST_WOKEN: begin
                if (!sleep_req) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        dom_en = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, rc: 1'b1};
        unique case (state)
            ST_RUN, ST_WOKEN: ;
            ST_IDLE: begin
                dom_en.cpu   = 1'b0;
                dom_en.flash = 1'b0;
            end
            ST_ADCNR: begin
                dom_en.cpu   = 1'b0;
                dom_en.flash = 1'b0;
                dom_en.io    = 1'b0;
            end
            ST_PDOWN, ST_STBY: begin
                dom_en = '0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/clkctl_gate_reg.sv
module clkctl_gate_reg
    import clkctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  dom_en_t dom_en,
    input  logic    pll_req,
    input  logic    fuse_prog,
    output logic    cpu_en,
    output logic    flash_en,
    output logic    io_en,
    output logic    adc_en,
    output logic    rc_en,
    output logic    pll_on
);

    // Falling-edge registers: enables settle while the source clock is low
    always_ff @(negedge clk) begin
        if (rst) begin
            cpu_en   <= 1'b1;
            flash_en <= 1'b1;
            io_en    <= 1'b1;
            adc_en   <= 1'b1;
            rc_en    <= 1'b1;
            pll_on   <= fuse_prog;
        end else begin
            cpu_en   <= dom_en.cpu;
            flash_en <= dom_en.flash;
            io_en    <= dom_en.io;
            adc_en   <= dom_en.adc;
            rc_en    <= dom_en.rc;
            pll_on   <= pll_req & dom_en.rc;
        end
    end

endmodule

// File: rtl/clkctl_refdiv.sv
module clkctl_refdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int MAX_LOG = (1 << SEL_W) - 1;
    localparam int CNT_W   = (MAX_LOG < 1) ? 1 : MAX_LOG;

    logic [CNT_W-1:0] cnt, lim;
    logic [CNT_W:0]   ratio;

    always_comb begin
        ratio = (CNT_W+1)'(1) << sel;
        lim   = CNT_W'(ratio - (CNT_W+1)'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CNT_W'(1);
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/clkctl_lock_fsm.sv
module clkctl_lock_fsm
    import clkctl_pkg::*;
#(
    parameter int LOCK_TICKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic pll_on,
    input  logic ref_tick,
    output logic locked
);

    localparam int CNT_W = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1;

    lock_st_e         state, state_d;
    logic [CNT_W-1:0] cnt, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LK_OFF;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        unique case (state)
            LK_OFF: begin
                cnt_d = '0;
                if (pll_on) state_d = LK_SETTLE;
            end
            LK_SETTLE: begin
                if (!pll_on) begin
                    state_d = LK_OFF;
                    cnt_d   = '0;
                end else if (ref_tick) begin
                    if (cnt == CNT_W'(LOCK_TICKS - 1)) state_d = LK_LOCKED;
                    else                              cnt_d   = cnt + CNT_W'(1);
                end
            end
            LK_LOCKED: begin
                if (!pll_on) begin
                    state_d = LK_OFF;
                    cnt_d   = '0;
                end
            end
            default: state_d = LK_OFF;
        endcase
    end

    always_comb begin
        locked = (state == LK_LOCKED);
    end

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top #(
    parameter int SEL_W      = 2,
    parameter int MODE_W     = 2,
    parameter int LOCK_TICKS = 64
) (
    input  logic              clk_src,
    input  logic              rst,
    input  logic              sleep_req,
    input  logic [MODE_W-1:0] sleep_mode,
    input  logic              wake_irq,
    input  logic              pll_en_bit,
    input  logic              pll_fuse_n,
    input  logic [SEL_W-1:0]  rc_freq_sel,
    input  logic              tmr_fast_sel,
    output logic              cpu_clk_en,
    output logic              flash_clk_en,
    output logic              io_clk_en,
    output logic              adc_clk_en,
    output logic              rc_osc_en,
    output logic              pll_en,
    output logic              ref_tick,
    output logic              pll_lock,
    output logic              pck_timer_sel
);

    import clkctl_pkg::*;

    dom_en_t dom_en;
    logic    pll_req;

    assign pll_req = pll_en_bit | ~pll_fuse_n;

    clkctl_sleep_fsm u_sleep (
        .clk       (clk_src),
        .rst       (rst),
        .sleep_req (sleep_req),
        .mode      (sleep_mode[1:0]),
        .wake_irq  (wake_irq),
        .dom_en    (dom_en)
    );

    clkctl_gate_reg u_gate (
        .clk       (clk_src),
        .rst       (rst),
        .dom_en    (dom_en),
        .pll_req   (pll_req),
        .fuse_prog (~pll_fuse_n),
        .cpu_en    (cpu_clk_en),
        .flash_en  (flash_clk_en),
        .io_en     (io_clk_en),
        .adc_en    (adc_clk_en),
        .rc_en     (rc_osc_en),
        .pll_on    (pll_en)
    );

    clkctl_refdiv #(.SEL_W(SEL_W)) u_div (
        .clk  (clk_src),
        .rst  (rst),
        .run  (rc_osc_en),
        .sel  (rc_freq_sel),
        .tick (ref_tick)
    );

    clkctl_lock_fsm #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
        .clk      (clk_src),
        .rst      (rst),
        .pll_on   (pll_en),
        .ref_tick (ref_tick),
        .locked   (pll_lock)
    );

    assign pck_timer_sel = tmr_fast_sel & pll_lock;

endmodule

// File: rtl/clkctl_sva.sv
module clkctl_sva (
    input logic clk_src,
    input logic rst,
    input logic sleep_req,
    input logic cpu_clk_en,
    input logic flash_clk_en,
    input logic io_clk_en,
    input logic adc_clk_en,
    input logic rc_osc_en,
    input logic pll_en,
    input logic pll_lock,
    input logic pck_timer_sel
);

    // R2: a running CPU implies flash, I/O and ADC running
    p_cpu_hier_r2: assert property (@(posedge clk_src) disable iff (rst)
        cpu_clk_en |-> (flash_clk_en && io_clk_en && adc_clk_en));

    // R5: the PLL is never powered without the RC oscillator
    p_pll_needs_rc_r5: assert property (@(posedge clk_src) disable iff (rst)
        pll_en |-> rc_osc_en);

    // R8: lock flag drops the cycle after PLL power goes away
    p_lock_drop_r8: assert property (@(posedge clk_src) disable iff (rst)
        !pll_en |=> !pll_lock);

    // R8: lock only while the PLL was powered on the previous edge
    p_lock_powered_r8: assert property (@(posedge clk_src) disable iff (rst)
        pll_lock |-> $past(pll_en));

    // R11: timer fast-clock grant requires lock
    p_tsel_locked_r11: assert property (@(posedge clk_src) disable iff (rst)
        pck_timer_sel |-> pll_lock);

    // R10: a sleep request held low keeps the CPU clock running
    p_awake_run_r10: assert property (@(posedge clk_src) disable iff (rst)
        ($past(!sleep_req) && $past(!sleep_req, 2)) |-> cpu_clk_en);

endmodule

bind clkctl_top clkctl_sva u_sva (.*);

// File: tb/clkctl_top_tb.sv
module clkctl_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic [1:0] sleep_mode = 2'b00;
    logic       wake_irq = 1'b0;
    logic       pll_en_bit = 1'b0;
    logic       pll_fuse_n = 1'b0;
    logic [1:0] rc_freq_sel = 2'b00;
    logic       tmr_fast_sel = 1'b0;
    logic cpu_en, flash_en, io_en, adc_en, rc_en, pll_on, tick, lock, tsel;

    always #10 clk = ~clk;

    clkctl_top u_dut (
        .clk_src(clk), .rst(rst), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .wake_irq(wake_irq), .pll_en_bit(pll_en_bit), .pll_fuse_n(pll_fuse_n),
        .rc_freq_sel(rc_freq_sel), .tmr_fast_sel(tmr_fast_sel),
        .cpu_clk_en(cpu_en), .flash_clk_en(flash_en), .io_clk_en(io_en),
        .adc_clk_en(adc_en), .rc_osc_en(rc_en), .pll_en(pll_on), .ref_tick(tick),
        .pll_lock(lock), .pck_timer_sel(tsel)
    );

    typedef struct {
        string req;
        bit    is_cnt;
        logic [7:0] mask;
        logic [7:0] val;
        int    cnt;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_fail = 0;
    int    tick_cnt = 0;
    bit    count_on = 1'b0;

    always @(negedge clk) if (count_on && tick) tick_cnt++;

    // Monitor: pops expected items and compares with observed outputs
    initial forever begin
        @(chk_ev);
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] obs;
            it  = q.pop_front();
            obs = {cpu_en, flash_en, io_en, adc_en, rc_en, pll_on, lock, tsel};
            n_chk++;
            if (it.is_cnt) begin
                if (tick_cnt != it.cnt) begin
                    n_fail++;
                    $display("FAIL %s: tick count actual %0d expected %0d", it.req, tick_cnt, it.cnt);
                end
            end else if ((obs & it.mask) !== (it.val & it.mask)) begin
                n_fail++;
                $display("FAIL %s: actual %b expected %b (mask %b)", it.req, obs & it.mask,
                         it.val & it.mask, it.mask);
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic expect_vec(string req, logic [7:0] mask, logic [7:0] val);
        item_t it;
        it = '{req: req, is_cnt: 1'b0, mask: mask, val: val, cnt: 0};
        q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic expect_ticks(string req, int exp_cnt, int cycles);
        item_t it;
        tick_cnt = 0;
        count_on = 1'b1;
        step(cycles);
        count_on = 1'b0;
        it = '{req: req, is_cnt: 1'b1, mask: 8'h00, val: 8'h00, cnt: exp_cnt};
        q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic pulse_wake();
        #3 wake_irq = 1'b1;
        #2 wake_irq = 1'b0;
    endtask

    // bit order: cpu flash io adc rc pll lock tsel
    initial begin
        step(3);
        expect_vec("R1 reset fuse programmed", 8'hFF, 8'b1111_1100);
        pll_fuse_n = 1'b1;
        step(2);
        expect_vec("R1 reset fuse blank", 8'hFF, 8'b1111_1000);
        rst = 1'b0;
        step(2);
        expect_vec("R2 run all domains", 8'hF8, 8'b1111_1000);

        for (int s = 0; s < 4; s++) begin
            rc_freq_sel = 2'(s);
            step(16);
            expect_ticks($sformatf("R7 tick rate code %0d", s), 64 >> s, 64);
        end

        // R8 / R11 lock with code 0
        rc_freq_sel = 2'd0;
        tmr_fast_sel = 1'b1;
        step(4);
        pll_en_bit = 1'b1;
        step(61);
        expect_vec("R8 no early lock r1", 8'h07, 8'b0000_0100);
        expect_vec("R11 no grant before lock", 8'h01, 8'h00);
        step(7);
        expect_vec("R8 lock reached r1", 8'h07, 8'b0000_0111);

        sleep_req = 1'b1; sleep_mode = 2'b00;
        step(2);
        expect_vec("R3 idle gating", 8'hFF, 8'b0011_1111);
        sleep_req = 1'b0;
        step(2);
        expect_vec("R10 back to run", 8'hFF, 8'b1111_1111);

        sleep_req = 1'b1; sleep_mode = 2'b01;
        step(2);
        expect_vec("R4 adc noise gating", 8'hF8, 8'b0001_1000);
        sleep_req = 1'b0;
        step(2);
        expect_vec("R10 leave adc mode", 8'hF0, 8'hF0);

        sleep_req = 1'b1;
        step(2);
        expect_vec("R9 asleep before wake", 8'hF0, 8'b0001_0000);
        pulse_wake();
        step(2);
        expect_vec("R9 wake restores", 8'hF0, 8'hF0);
        step(5);
        expect_vec("R9 stays awake", 8'hF0, 8'hF0);
        sleep_req = 1'b0;
        step(2);
        sleep_req = 1'b1;
        step(2);
        expect_vec("R9 sleeps again", 8'hF0, 8'b0001_0000);
        sleep_req = 1'b0;
        step(2);

        sleep_req = 1'b1; sleep_mode = 2'b10;
        step(2);
        expect_vec("R5 power-down all off", 8'hFF, 8'h00);
        expect_ticks("R5 no ticks in power-down", 0, 32);
        sleep_mode = 2'b11;
        sleep_req = 1'b0;
        step(2);
        sleep_req = 1'b1;
        pll_fuse_n = 1'b0;
        step(2);
        expect_vec("R5 standby with fuse", 8'hFC, 8'h00);
        sleep_req = 1'b0;
        step(2);
        expect_vec("R6 relaunch after deep", 8'hFE, 8'b1111_1100);

        pll_en_bit = 1'b0; pll_fuse_n = 1'b1;
        step(2);
        expect_vec("R6 both off", 8'h06, 8'h00);
        pll_fuse_n = 1'b0;
        step(2);
        expect_vec("R6 fuse alone", 8'h04, 8'h04);

        // R8 with code 3: remove power to clear, then relock
        rc_freq_sel = 2'd3;
        pll_fuse_n = 1'b1;
        step(3);
        expect_vec("R8 cleared on disable", 8'h07, 8'h00);
        pll_fuse_n = 1'b0;
        step(63 * 8 - 2);
        expect_vec("R8 no early lock r8", 8'h06, 8'h04);
        step(16);
        expect_vec("R8 lock reached r8", 8'h07, 8'h07);
        tmr_fast_sel = 1'b0;
        step(1);
        expect_vec("R11 no grant without request", 8'h03, 8'h02);

        step(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule